// File: doc/BRIEF.md
# SPI chip-select sequencer

This block owns the chip-select lines of an SPI host and sequences them around the frames that a separate shift engine produces. When a transmit word is pending, it selects one line by its ID, waits a programmable number of SCK periods, and then tells the shift engine to start a frame. When the engine reports the last SCK edge, the block keeps the line selected for a programmable tail and then releases it. After release it holds the line idle for a minimum time before it can select again.

Each line has its own idle level, and the selected line is driven to the opposite of that level. Three selection behaviours are offered. The first asserts and releases the line once per frame. The second keeps the line asserted across frames until software changes the mode or the ID; while the line is held, a separate inter-frame gap spaces consecutive frames. The third never asserts any line, and frames start with no chip-select timing at all.

Configuration arrives through a simple write port that carries a select code and 32 data bits. The idle-level register can be read back. Delays count pulses on `tick_i`, which gives one pulse per SCK period. With `tick_i` held high, every delay below is in clock cycles.

Top module: `spi_cs_seq`

## Requirements
- R1: Write select 2 loads the mode from data bits [1:0]. The value 0 means per-frame select, and 1 behaves exactly like 0. The value 2 means held select. The value 3 means no select: no line ever leaves its idle level, and `frame_start_o` pulses in the first cycle after `tx_valid_i` is seen while idle.
- R2: Write select 0 loads the line ID from data bits [4:0]. While selected, line `id` is driven to the inverse of its idle bit and every other line stays at its idle level. An ID of `NUM_CS` or more changes no line, but frames still run.
- R3: In per-frame or held mode, chip select asserts in the cycle after `tx_valid_i` is seen while idle. `frame_start_o` pulses exactly `pre` ticks later, so with `pre` = 0 it pulses in the same cycle as the assertion. Write select 3 loads `pre` from data bits [7:0] and `post` from data bits [15:8].
- R4: After a frame ends in per-frame mode, chip select stays asserted for `post`+1 cycles, counted from the cycle after `frame_done_i` is high.
- R5: Once deasserted, chip select stays deasserted for at least `gap_cs`+1 cycles. When `tx_valid_i` is already high, it reasserts after exactly that time. Write select 4 loads `gap_cs` from data bits [7:0] and `gap_frame` from data bits [15:8].
- R6: In held mode, the line stays asserted after a frame ends. A pending word then starts the next frame `gap_frame` ticks after the first cycle following the one in which `tx_valid_i` is seen.
- R7: A held line is released when the mode is written to a non-held value or when the ID changes. The release follows the `post` delay and then the `gap_cs` time. The line drops `post`+2 cycles after the cycle in which the write is applied.
- R8: After reset, `pre`, `post` and `gap_cs` are 1, `gap_frame` is 0, the mode is 0, the ID is 0, and every implemented idle bit is 1.
- R9: Write select 1 loads the idle levels from data bits [NUM_CS-1:0]. `def_level_o` returns those bits, and bits at or above `NUM_CS` read as zero.
- R10: Delay counters advance only on cycles with `tick_i` high. While `tick_i` is low, a pending delay does not expire.
- R11: `frame_start_o` is a single-cycle pulse. It does not recur before `frame_done_i` for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 3 | Configuration target select |
| cfg_wdata_i | input | 32 | Configuration write data |
| def_level_o | output | 32 | Idle-level readback, upper bits zero |
| tick_i | input | 1 | One pulse per SCK period |
| tx_valid_i | input | 1 | Transmit word pending |
| frame_start_o | output | 1 | Start pulse to the shift engine |
| frame_done_i | input | 1 | Shift engine finished last SCK edge |
| cs_o | output | NUM_CS | Chip-select lines |

## Verification
A configuration write is sampled at one clock edge and applies from the next. A pending word therefore moves chip select one cycle after it is seen. `frame_start_o` follows the assertion by exactly `pre` ticks, and a release lands `post`+1 cycles after `frame_done_i`, or `post`+2 cycles after a releasing write. The bench drives and samples on the falling edge, so each sample shows the state after the preceding rising edge. It measures every interval by counting consecutive falling-edge samples in one state and compares the count with the value derived from the programmed delay.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  localparam int MAX_CS = 32;
  localparam int ID_W   = $clog2(MAX_CS);

  typedef enum logic [1:0] {
    CSM_AUTO     = 2'd0,
    CSM_AUTO_ALT = 2'd1,
    CSM_HOLD     = 2'd2,
    CSM_OFF      = 2'd3
  } cs_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_XFER, ST_POST, ST_INACT, ST_HOLD, ST_GAP
  } seq_state_e;

  localparam logic [2:0] SEL_ID   = 3'd0;
  localparam logic [2:0] SEL_DEF  = 3'd1;
  localparam logic [2:0] SEL_MODE = 3'd2;
  localparam logic [2:0] SEL_EDGE = 3'd3;
  localparam logic [2:0] SEL_GAP  = 3'd4;
endpackage

// File: rtl/spi_cs_cfg.sv
module spi_cs_cfg
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DLY_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [31:0]       wdata_i,
  output logic [ID_W-1:0]   id_o,
  output logic [NUM_CS-1:0] def_o,
  output cs_mode_e          mode_o,
  output logic [DLY_W-1:0]  pre_o,
  output logic [DLY_W-1:0]  post_o,
  output logic [DLY_W-1:0]  gap_cs_o,
  output logic [DLY_W-1:0]  gap_frame_o,
  output logic [31:0]       def_rd_o
);
  localparam int HI_LSB = DLY_W;
  localparam int HI_MSB = 2 * DLY_W - 1;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_o        <= '0;
      def_o       <= '1;
      mode_o      <= CSM_AUTO;
      pre_o       <= DLY_W'(1);
      post_o      <= DLY_W'(1);
      gap_cs_o    <= DLY_W'(1);
      gap_frame_o <= '0;
    end else if (we_i) begin
      unique case (sel_i)
        SEL_ID:   id_o   <= wdata_i[ID_W-1:0];
        SEL_DEF:  def_o  <= wdata_i[NUM_CS-1:0];
        SEL_MODE: mode_o <= cs_mode_e'(wdata_i[1:0]);
        SEL_EDGE: begin
          pre_o  <= wdata_i[DLY_W-1:0];
          post_o <= wdata_i[HI_MSB:HI_LSB];
        end
        SEL_GAP: begin
          gap_cs_o    <= wdata_i[DLY_W-1:0];
          gap_frame_o <= wdata_i[HI_MSB:HI_LSB];
        end
        default: ;
      endcase
    end
  end

  for (genvar b = 0; b < MAX_CS; b++) begin : g_rd
    if (b < NUM_CS) begin : g_impl
      assign def_rd_o[b] = def_o[b];
    end else begin : g_none
      assign def_rd_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/spi_cs_fsm.sv
module spi_cs_fsm
  import spi_cs_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             tx_valid_i,
  input  logic             frame_done_i,
  input  cs_mode_e         mode_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic [DLY_W-1:0] pre_i,
  input  logic [DLY_W-1:0] post_i,
  input  logic [DLY_W-1:0] gap_cs_i,
  input  logic [DLY_W-1:0] gap_frame_i,
  output logic             frame_start_o,
  output logic             cs_on_o,
  output logic [ID_W-1:0]  act_id_o,
  output seq_state_e       state_o
);
  seq_state_e       state_q, state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d, load_val;
  logic             load, cnt_zero, cs_act_q, cs_act_d;
  logic [ID_W-1:0]  act_id_q, act_id_d;
  logic             is_off, is_hold, keep_hold;

  assign cnt_zero  = (cnt_q == '0);
  assign is_off    = (mode_i == CSM_OFF);
  assign is_hold   = (mode_i == CSM_HOLD);
  assign keep_hold = is_hold && (id_i == act_id_q);

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    cs_act_d = cs_act_q;
    act_id_d = act_id_q;
    unique case (state_q)
      ST_IDLE, ST_INACT: begin
        if ((state_q == ST_IDLE || cnt_zero) && tx_valid_i) begin
          state_d  = ST_PRE;
          load     = 1'b1;
          load_val = is_off ? '0 : pre_i;
          cs_act_d = !is_off;
          act_id_d = id_i;
        end else if (state_q == ST_INACT && cnt_zero) begin
          state_d = ST_IDLE;
        end
      end
      ST_PRE, ST_GAP: if (cnt_zero) state_d = ST_XFER;
      ST_XFER: begin
        if (frame_done_i) begin
          if (!cs_act_q)      state_d = ST_IDLE;
          else if (keep_hold) state_d = ST_HOLD;
          else begin
            state_d  = ST_POST;
            load     = 1'b1;
            load_val = post_i;
          end
        end
      end
      ST_POST: begin
        if (cnt_zero) begin
          state_d  = ST_INACT;
          load     = 1'b1;
          load_val = gap_cs_i;
          cs_act_d = 1'b0;
        end
      end
      ST_HOLD: begin
        if (!keep_hold) begin
          state_d  = ST_POST;
          load     = 1'b1;
          load_val = post_i;
        end else if (tx_valid_i) begin
          state_d  = ST_GAP;
          load     = 1'b1;
          load_val = gap_frame_i;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (load)                    cnt_d = load_val;
    else if (tick_i && !cnt_zero) cnt_d = cnt_q - 1'b1;
    else                         cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      cs_act_q <= 1'b0;
      act_id_q <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      cs_act_q <= cs_act_d;
      act_id_q <= act_id_d;
    end
  end

  assign frame_start_o = (state_q == ST_PRE || state_q == ST_GAP) && cnt_zero;
  assign cs_on_o       = cs_act_q;
  assign act_id_o      = act_id_q;
  assign state_o       = state_q;
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic [NUM_CS-1:0] def_i,
  input  logic [ID_W-1:0]   act_id_i,
  input  logic              cs_on_i,
  output logic [NUM_CS-1:0] cs_o
);
  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs_o[i] = def_i[i] ^ (cs_on_i && (act_id_i == ID_W'(i)));
  end
endmodule

// File: rtl/spi_cs_seq.sv
module spi_cs_seq
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DLY_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_sel_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       def_level_o,
  input  logic              tick_i,
  input  logic              tx_valid_i,
  output logic              frame_start_o,
  input  logic              frame_done_i,
  output logic [NUM_CS-1:0] cs_o
);
  logic [ID_W-1:0]   id_q, act_id;
  logic [NUM_CS-1:0] def_q;
  cs_mode_e          mode_q;
  logic [DLY_W-1:0]  pre_q, post_q, ics_q, ifg_q;
  logic              cs_on;
  seq_state_e        state;

  spi_cs_cfg #(.NUM_CS(NUM_CS), .DLY_W(DLY_W)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .sel_i(cfg_sel_i), .wdata_i(cfg_wdata_i),
    .id_o(id_q), .def_o(def_q), .mode_o(mode_q),
    .pre_o(pre_q), .post_o(post_q), .gap_cs_o(ics_q), .gap_frame_o(ifg_q),
    .def_rd_o(def_level_o)
  );

  spi_cs_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk_i, .rst_ni, .tick_i, .tx_valid_i, .frame_done_i,
    .mode_i(mode_q), .id_i(id_q),
    .pre_i(pre_q), .post_i(post_q), .gap_cs_i(ics_q), .gap_frame_i(ifg_q),
    .frame_start_o, .cs_on_o(cs_on), .act_id_o(act_id), .state_o(state)
  );

  spi_cs_drive #(.NUM_CS(NUM_CS)) u_drive (
    .def_i(def_q), .act_id_i(act_id), .cs_on_i(cs_on), .cs_o
  );
endmodule

// File: rtl/spi_cs_seq_chk.sv
module spi_cs_seq_chk
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DLY_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic              tick_i,
  input logic              frame_start_o,
  input logic              frame_done_i,
  input logic [NUM_CS-1:0] cs_o,
  input logic [NUM_CS-1:0] def_q,
  input logic              cs_on,
  input seq_state_e        state,
  input cs_mode_e          mode_q,
  input logic [ID_W-1:0]   id_q,
  input logic [ID_W-1:0]   act_id,
  input logic [DLY_W-1:0]  ics_q
);
  p_one_line_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cs_o ^ def_q) <= 1);

  p_off_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && mode_q == CSM_OFF) |=> (cs_o == def_q));

  p_start_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);

  p_hold_keeps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && state == ST_XFER && cs_on && mode_q == CSM_HOLD &&
     id_q == act_id && !cfg_we_i) |=> (cs_o == $past(cs_o)));

  p_min_inactive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cs_on) && ics_q != '0) |=> !cs_on);

  p_tick_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state == ST_PRE || state == ST_GAP) && !tick_i && !frame_start_o) |=> !frame_start_o);
endmodule

bind spi_cs_seq spi_cs_seq_chk #(.NUM_CS(NUM_CS), .DLY_W(DLY_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .tick_i(tick_i),
  .frame_start_o(frame_start_o), .frame_done_i(frame_done_i), .cs_o(cs_o),
  .def_q(def_q), .cs_on(cs_on), .state(state), .mode_q(mode_q),
  .id_q(id_q), .act_id(act_id), .ics_q(ics_q)
);

// File: tb/spi_cs_seq_bench.sv
`timescale 1ns/1ps
module spi_cs_seq_bench;
  localparam int NCS = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_we_i = 1'b0, tick_i = 1'b1, tx_valid_i = 1'b0, frame_done_i = 1'b0;
  logic [2:0]  cfg_sel_i = 3'd0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] def_level_o;
  logic        frame_start_o;
  logic [NCS-1:0] cs_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [NCS-1:0] def_exp = '1;

  always #2.5 clk_i = ~clk_i;

  spi_cs_seq #(.NUM_CS(NCS), .DLY_W(8)) u_spi_cs_seq (.*);

  function automatic bit cs_active();
    return cs_o != def_exp;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic wait_start(output int n);
    n = 0;
    while (!frame_start_o && n < 1000) begin n++; @(negedge clk_i); end
  endtask

  task automatic count_cs(input bit on, output int n);
    n = 0;
    while (cs_active() == on && n < 1000) begin n++; @(negedge clk_i); end
  endtask

  // acts as shift engine: frame lasts len cycles after start
  task automatic finish_frame(input int len);
    bit quiet = 1;
    for (int i = 0; i < len; i++) begin
      @(negedge clk_i);
      if (frame_start_o) quiet = 0;
    end
    check(quiet, "R11 no restart inside frame", !quiet, 0);
    frame_done_i = 1'b1;
    @(negedge clk_i);
    frame_done_i = 1'b0;
  endtask

  task automatic t_reset();
    check(def_level_o == 32'hF, "R8/R9 idle levels at reset", def_level_o, 32'hF);
    check(cs_o == 4'hF, "R8 lines idle at reset", cs_o, 4'hF);
    check(!frame_start_o, "R11 no start at reset", frame_start_o, 0);
  endtask

  task automatic t_auto_default();
    int n;
    tx_valid_i = 1'b1;
    @(negedge clk_i);
    check(cs_active(), "R3 assert after word seen", cs_active(), 1);
    check(cs_o == 4'hE, "R2 line 0 selected", cs_o, 4'hE);
    wait_start(n);
    check(n == 1, "R8 reset pre delay", n, 1);
    tx_valid_i = 1'b0;
    @(negedge clk_i);
    check(!frame_start_o, "R11 start is one cycle", frame_start_o, 0);
    finish_frame(3);
    tx_valid_i = 1'b1;
    count_cs(1, n);
    check(n == 2, "R4 reset post delay", n, 2);
    count_cs(0, n);
    check(n == 2, "R5 reset inactive time", n, 2);
    wait_start(n);
    check(n == 1, "R3 second frame pre", n, 1);
    tx_valid_i = 1'b0;
    @(negedge clk_i);
    finish_frame(2);
    repeat (8) @(negedge clk_i);
  endtask

  task automatic t_mode_alt();
    int n;
    cfg_write(3'd2, 32'd1);
    tx_valid_i = 1'b1;
    @(negedge clk_i);
    wait_start(n);
    tx_valid_i = 1'b0;
    @(negedge clk_i);
    finish_frame(2);
    count_cs(1, n);
    check(n == 2, "R1 mode 1 releases like mode 0", n, 2);
    repeat (6) @(negedge clk_i);
  endtask

  task automatic t_off();
    bit quiet = 1;
    cfg_write(3'd2, 32'd3);
    tx_valid_i = 1'b1;
    @(negedge clk_i);
    check(frame_start_o == 1'b1, "R1 off mode starts at once", frame_start_o, 1);
    check(cs_o == def_exp, "R1 off mode no select", cs_o, def_exp);
    tx_valid_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (cs_o != def_exp) quiet = 0;
      frame_done_i = (i == 3);
    end
    frame_done_i = 1'b0;
    check(quiet, "R1 off mode lines stay idle", !quiet, 0);
    cfg_write(3'd2, 32'd0);
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_decode();
    int n;
    cfg_write(3'd1, 32'hFFFF_FFF5);
    def_exp = 4'h5;
    check(def_level_o == 32'h5, "R9 upper idle bits read zero", def_level_o, 32'h5);
    check(cs_o == 4'h5, "R9 idle levels drive lines", cs_o, 4'h5);
    cfg_write(3'd0, 32'd1);
    tx_valid_i = 1'b1;
    @(negedge clk_i);
    check(cs_o == 4'h7, "R2 line 1 driven to inverse", cs_o, 4'h7);
    wait_start(n);
    tx_valid_i = 1'b0;
    @(negedge clk_i);
    finish_frame(2);
    repeat (8) @(negedge clk_i);
    cfg_write(3'd0, 32'd6);
    tx_valid_i = 1'b1;
    @(negedge clk_i);
    wait_start(n);
    check(n == 1 && cs_o == 4'h5, "R2 out of range id selects none", cs_o, 4'h5);
    tx_valid_i = 1'b0;
    @(negedge clk_i);
    finish_frame(2);
    repeat (8) @(negedge clk_i);
    cfg_write(3'd0, 32'd0);
    cfg_write(3'd1, 32'hFFFF_FFFF);
    def_exp = 4'hF;
  endtask

  task automatic t_hold();
    int n;
    bit held = 1;
    cfg_write(3'd2, 32'd2);
    tx_valid_i = 1'b1;
    @(negedge clk_i);
    wait_start(n);
    tx_valid_i = 1'b0;
    @(negedge clk_i);
    finish_frame(2);
    for (int i = 0; i < 10; i++) begin
      if (!cs_active()) held = 0;
      @(negedge clk_i);
    end
    check(held, "R6 line held after frame", !held, 0);
    tx_valid_i = 1'b1;
    @(negedge clk_i);
    wait_start(n);
    check(n == 0 && cs_active(), "R8 reset inter-frame gap 0", n, 0);
    tx_valid_i = 1'b0;
    @(negedge clk_i);
    finish_frame(2);
    cfg_write(3'd4, 32'h0000_0301);
    tx_valid_i = 1'b1;
    @(negedge clk_i);
    wait_start(n);
    check(n == 3 && cs_active(), "R6 inter-frame gap 3", n, 3);
    tx_valid_i = 1'b0;
    @(negedge clk_i);
    finish_frame(2);
    cfg_write(3'd0, 32'd2);
    count_cs(1, n);
    check(n == 3, "R7 release on id change", n, 3);
    repeat (6) @(negedge clk_i);
    tx_valid_i = 1'b1;
    @(negedge clk_i);
    check(cs_o == 4'hB, "R2 line 2 held select", cs_o, 4'hB);
    wait_start(n);
    tx_valid_i = 1'b0;
    @(negedge clk_i);
    finish_frame(2);
    cfg_write(3'd2, 32'd0);
    count_cs(1, n);
    check(n == 3, "R7 release on mode write", n, 3);
    repeat (6) @(negedge clk_i);
    cfg_write(3'd0, 32'd0);
  endtask

  task automatic t_edges();
    int n;
    cfg_write(3'd3, 32'h0000_0300);
    cfg_write(3'd4, 32'h0000_0000);
    tx_valid_i = 1'b1;
    @(negedge clk_i);
    check(cs_active() && frame_start_o, "R3 pre 0 starts with select", frame_start_o, 1);
    tx_valid_i = 1'b0;
    @(negedge clk_i);
    finish_frame(2);
    tx_valid_i = 1'b1;
    count_cs(1, n);
    check(n == 4, "R4 post delay 3", n, 4);
    count_cs(0, n);
    check(n == 1, "R5 inactive time 0", n, 1);
    wait_start(n);
    check(n == 0, "R3 pre 0 on reselect", n, 0);
    tx_valid_i = 1'b0;
    @(negedge clk_i);
    finish_frame(2);
    repeat (8) @(negedge clk_i);
    cfg_write(3'd3, 32'h0000_0101);
    cfg_write(3'd4, 32'h0000_0001);
  endtask

  task automatic t_tick();
    bit quiet = 1;
    int n;
    tick_i = 1'b0;
    tx_valid_i = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < 20; i++) begin
      if (frame_start_o || !cs_active()) quiet = 0;
      @(negedge clk_i);
    end
    check(quiet, "R10 no expiry without tick", !quiet, 0);
    tick_i = 1'b1;
    @(negedge clk_i);
    check(frame_start_o == 1'b1, "R10 expiry on tick", frame_start_o, 1);
    tx_valid_i = 1'b0;
    @(negedge clk_i);
    finish_frame(2);
    count_cs(1, n);
    repeat (6) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_auto_default();
    t_mode_alt();
    t_off();
    t_decode();
    t_hold();
    t_edges();
    t_tick();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      summary();
      $finish;
    end
  end
endmodule